// File: doc/BRIEF.md
# Two-Level Routed Priority Interrupt Controller

This block gathers 64 system event lines, latches each one as a pending status bit, and routes it to one of ten host interrupt outputs. Routing happens in two steps. Each event is mapped to one of ten channels, and each channel is mapped to one of ten hosts. Each event line has programmable polarity and a programmable choice between edge capture and level capture. Each event also has its own enable. The hosts have individual enables, and one global enable gates all host outputs.

For every host, the block keeps a registered index word. It names the highest-priority event that is pending, enabled and routed to that host, or it flags that no such event exists. A handler reads this word, clears the event it names, and reads again, until the word reports that nothing is pending.

Software reaches the block over a simple 32-bit bus with word addresses and a one-cycle read latency. Status and enable state can be changed either through 32-bit bitmask words or by writing a single event number to an indexed word.

Top module: `icx_top`

## Requirements
- R1: A synchronous reset has these effects:
  - Status, event enables, channel and host maps, host enables and the global enable all read as 0.
  - The polarity words (0x0E for bank 0, 0x0F for bank 1) read as 0xFFFFFFFF.
  - Every host index word reads as 0x80000000.
  - host_irq is all low.
- R2: An event of pulse type has type bit 0. Type words are 0x10 for events 0–31 and 0x11 for events 32–63. Such an event sets its status bit only on the transition of its line from inactive to active. The bit stays set after the line returns to inactive. If the bit is cleared while the line is held active, it is not set again.
- R3: An event of level type has type bit 1. It sets its status bit on every cycle that its line is active. A clear made while the line is still active is undone on the next cycle.
- R4: A polarity bit of 1 means the line is active-high, and 0 means active-low. Bank 0 holds events 0–31 and bank 1 holds events 32–63.
- R5: The raw status words 0x08 and 0x09 record events whether or not the events are enabled. Only an event that is both pending and enabled counts toward a host index word or a host output.
- R6: Bitmask writes act only on the bits written as 1:
  - Enable-set words 0x0A/0x0B and enable-clear words 0x0C/0x0D both read back the current enables.
  - Status-clear words are 0x08/0x09.
- R7: The indexed words take an event number as write data. Word 0x04 clears that event's status, 0x05 sets its enable, 0x06 clears its enable and 0x07 sets its status. Event numbers of 64 and above are ignored.
- R8: The channel map sits in words 0x20–0x2F. Event i is held in word 0x20+i/4, in bits [8*(i%4)+3 : 8*(i%4)]. All other bits read as 0.
- R9: The host map sits in words 0x30–0x32 and packs channels the same way. The slots for the non-existent channels 10 and 11 read as 0. A map value from 10 to 15, at either level, routes the event or channel nowhere.
- R10: Among the qualifying events of one host, the event on the lowest-numbered channel wins. Within that channel, the lowest event number wins.
- R11: Host h has an index word at 0x40+h. When an event qualifies, bits 9:0 hold the number of the winning event and bit 31 is 0. When no event qualifies, the word reads 0x80000000.
- R12: host_irq[h] is high when all three of the following hold: the global enable (bit 0 of word 0x00) is set, host h is enabled, and at least one event for host h qualifies. Writing h to word 0x02 sets the enable of host h, and writing h to word 0x03 clears it. Word 0x01 reads the host enables as a mask. Host numbers of 10 and above are ignored.
- R13: A line that becomes active before clock edge k sets its status bit at edge k. The matching host_irq output and index word update at edge k+1. Read data appears one edge after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 64 | System event lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| host_irq | output | 10 | Host interrupt outputs |

## Verification
The bench aims at the priority order. It makes an event on a lower channel but with a higher number pend alongside a lower-numbered event on a later channel. A design that ranked events by number alone would report the wrong index. The bench also clears a level event while its line is still active and clears a pulse event while its line is held. A design that let the clear win permanently, or that re-armed an edge on a held line, would read back the wrong status. It further writes out-of-range map values, out-of-range indexed numbers and all-zero bitmasks. A design that decoded too few bits would misroute the event or corrupt state. Finally, it samples host_irq on the cycle the status sets and on the cycle after, which catches an extra or a missing register stage.

// File: rtl/icx_pkg.sv
package icx_pkg;
  localparam int EVT_N  = 64;
  localparam int CH_N   = 10;
  localparam int HOST_N = 10;
  localparam int MAP_W  = 4;
  localparam int IDX_W  = 10;

  // word addresses
  localparam int A_GLB   = 0;
  localparam int A_HEN   = 1;
  localparam int A_HSET  = 2;
  localparam int A_HCLR  = 3;
  localparam int A_ISCLR = 4;
  localparam int A_IESET = 5;
  localparam int A_IECLR = 6;
  localparam int A_ISSET = 7;
  localparam int A_STAT  = 8;
  localparam int A_ENSET = 10;
  localparam int A_ENCLR = 12;
  localparam int A_POL   = 14;
  localparam int A_TYP   = 16;
  localparam int A_CMAP  = 32;
  localparam int A_HMAP  = 48;
  localparam int A_HIDX  = 64;
endpackage

// File: rtl/icx_evt_capture.sv
module icx_evt_capture #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_in,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] typ,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] status
);
  logic [N-1:0] act, act_q, hw_set;

  assign act    = ~(evt_in ^ pol);
  assign hw_set = (typ & act) | (~typ & act & ~act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      status <= '0;
    end else begin
      act_q  <= act;
      status <= (status | hw_set | set_mask) & ~clr_mask;
    end
  end

  // R2: a latched bit only drops through an explicit clear
  a_r2_status_held: assert property (@(posedge clk) disable iff (rst)
    ((($past(status) & ~$past(clr_mask)) & ~status) == '0));

  // R3: an active level line without a clear is pending one cycle later
  a_r3_level_sets: assert property (@(posedge clk) disable iff (rst)
    (($past(typ & act & ~clr_mask) & ~status) == '0));
endmodule

// File: rtl/icx_chan_route.sv
module icx_chan_route #(
  parameter int N_EVT = 64,
  parameter int N_CH  = 10,
  parameter int MAP_W = 4,
  parameter int EW    = $clog2(N_EVT)
) (
  input  logic [N_EVT-1:0]            pend,
  input  logic [N_EVT-1:0][MAP_W-1:0] cmap,
  output logic [N_CH-1:0]             ch_hit,
  output logic [N_CH-1:0][EW-1:0]     ch_evt
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic          hit_l;
    logic [EW-1:0] evt_l;
    always_comb begin
      hit_l = 1'b0;
      evt_l = '0;
      for (int e = N_EVT - 1; e >= 0; e--) begin
        if (pend[e] && cmap[e] == MAP_W'(c)) begin
          hit_l = 1'b1;
          evt_l = EW'(e);
        end
      end
    end
    assign ch_hit[c] = hit_l;
    assign ch_evt[c] = evt_l;
  end
endmodule

// File: rtl/icx_host_sel.sv
module icx_host_sel #(
  parameter int N_EVT  = 64,
  parameter int N_CH   = 10,
  parameter int N_HOST = 10,
  parameter int MAP_W  = 4,
  parameter int EW     = $clog2(N_EVT)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_EVT-1:0]           pend,
  input  logic [N_CH-1:0]            ch_hit,
  input  logic [N_CH-1:0][EW-1:0]    ch_evt,
  input  logic [N_CH-1:0][MAP_W-1:0] hmap,
  input  logic                       glb_en,
  input  logic [N_HOST-1:0]          host_en,
  output logic [N_HOST-1:0]          host_irq,
  output logic [N_HOST-1:0]          none_q,
  output logic [N_HOST-1:0][EW-1:0]  evt_q
);
  logic [N_EVT-1:0] pend_prev;

  always_ff @(posedge clk) begin
    if (rst) pend_prev <= '0;
    else     pend_prev <= pend;
  end

  for (genvar h = 0; h < N_HOST; h++) begin : g_host
    logic          any_l, irq_r, none_r;
    logic [EW-1:0] sel_l, evt_r;

    always_comb begin
      any_l = 1'b0;
      sel_l = '0;
      for (int c = N_CH - 1; c >= 0; c--) begin
        if (ch_hit[c] && hmap[c] == MAP_W'(h)) begin
          any_l = 1'b1;
          sel_l = ch_evt[c];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        irq_r  <= 1'b0;
        none_r <= 1'b1;
        evt_r  <= '0;
      end else begin
        irq_r  <= glb_en & host_en[h] & any_l;
        none_r <= ~any_l;
        evt_r  <= any_l ? sel_l : '0;
      end
    end

    assign host_irq[h] = irq_r;
    assign none_q[h]   = none_r;
    assign evt_q[h]    = evt_r;

    // R12: an asserted output always has a reported event
    a_r12_irq_has_event: assert property (@(posedge clk) disable iff (rst)
      irq_r |-> !none_r);
    // R12: output only with both enables on in the prior cycle
    a_r12_irq_gated: assert property (@(posedge clk) disable iff (rst)
      irq_r |-> $past(glb_en && host_en[h]));
    // R10: the reported event was pending and enabled
    a_r10_idx_pending: assert property (@(posedge clk) disable iff (rst)
      !none_r |-> pend_prev[evt_r]);
  end
endmodule

// File: rtl/icx_top.sv
module icx_top
  import icx_pkg::*;
#(
  parameter int NUM_EVT  = EVT_N,
  parameter int NUM_CH   = CH_N,
  parameter int NUM_HOST = HOST_N,
  parameter int MAPW     = MAP_W,
  parameter int ADDR_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_HOST-1:0] host_irq
);
  localparam int BANKS = NUM_EVT / 32;
  localparam int EW    = $clog2(NUM_EVT);
  localparam int HW    = $clog2(NUM_HOST);

  logic                            glb_en;
  logic [NUM_HOST-1:0]             host_en;
  logic [NUM_EVT-1:0]              enable, pol, typ, status;
  logic [NUM_EVT-1:0]              st_set, st_clr;
  logic [NUM_EVT-1:0][MAPW-1:0]    cmap;
  logic [NUM_CH-1:0][MAPW-1:0]     hmap;
  logic [NUM_CH-1:0]               ch_hit;
  logic [NUM_CH-1:0][EW-1:0]       ch_evt;
  logic [NUM_HOST-1:0]             none_q;
  logic [NUM_HOST-1:0][EW-1:0]     evt_q;
  logic [31:0]                     rd_mux;
  logic                            evt_ok, host_ok;

  assign evt_ok  = bus_wdata < 32'(NUM_EVT);
  assign host_ok = bus_wdata < 32'(NUM_HOST);

  // status set / clear requests
  always_comb begin
    st_set = '0;
    st_clr = '0;
    if (bus_wr) begin
      for (int b = 0; b < BANKS; b++)
        if (bus_addr == ADDR_W'(A_STAT + b)) st_clr[b*32 +: 32] = bus_wdata;
      if (bus_addr == ADDR_W'(A_ISCLR) && evt_ok) st_clr[bus_wdata[EW-1:0]] = 1'b1;
      if (bus_addr == ADDR_W'(A_ISSET) && evt_ok) st_set[bus_wdata[EW-1:0]] = 1'b1;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en  <= 1'b0;
      host_en <= '0;
      enable  <= '0;
      pol     <= '1;
      typ     <= '0;
      cmap    <= '0;
      hmap    <= '0;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_GLB)) glb_en <= bus_wdata[0];
      if (bus_addr == ADDR_W'(A_HSET) && host_ok) host_en[bus_wdata[HW-1:0]] <= 1'b1;
      if (bus_addr == ADDR_W'(A_HCLR) && host_ok) host_en[bus_wdata[HW-1:0]] <= 1'b0;
      if (bus_addr == ADDR_W'(A_IESET) && evt_ok) enable[bus_wdata[EW-1:0]] <= 1'b1;
      if (bus_addr == ADDR_W'(A_IECLR) && evt_ok) enable[bus_wdata[EW-1:0]] <= 1'b0;
      for (int b = 0; b < BANKS; b++) begin
        if (bus_addr == ADDR_W'(A_ENSET + b))
          enable[b*32 +: 32] <= enable[b*32 +: 32] | bus_wdata;
        if (bus_addr == ADDR_W'(A_ENCLR + b))
          enable[b*32 +: 32] <= enable[b*32 +: 32] & ~bus_wdata;
        if (bus_addr == ADDR_W'(A_POL + b)) pol[b*32 +: 32] <= bus_wdata;
        if (bus_addr == ADDR_W'(A_TYP + b)) typ[b*32 +: 32] <= bus_wdata;
      end
      for (int e = 0; e < NUM_EVT; e++)
        if (bus_addr == ADDR_W'(A_CMAP + e / 4)) cmap[e] <= bus_wdata[8*(e%4) +: MAPW];
      for (int c = 0; c < NUM_CH; c++)
        if (bus_addr == ADDR_W'(A_HMAP + c / 4)) hmap[c] <= bus_wdata[8*(c%4) +: MAPW];
    end
  end

  icx_evt_capture #(.N(NUM_EVT)) u_cap (
    .clk(clk), .rst(rst), .evt_in(evt_in), .pol(pol), .typ(typ),
    .set_mask(st_set), .clr_mask(st_clr), .status(status)
  );

  icx_chan_route #(.N_EVT(NUM_EVT), .N_CH(NUM_CH), .MAP_W(MAPW), .EW(EW)) u_route (
    .pend(status & enable), .cmap(cmap), .ch_hit(ch_hit), .ch_evt(ch_evt)
  );

  icx_host_sel #(.N_EVT(NUM_EVT), .N_CH(NUM_CH), .N_HOST(NUM_HOST), .MAP_W(MAPW), .EW(EW)) u_sel (
    .clk(clk), .rst(rst), .pend(status & enable), .ch_hit(ch_hit), .ch_evt(ch_evt),
    .hmap(hmap), .glb_en(glb_en), .host_en(host_en),
    .host_irq(host_irq), .none_q(none_q), .evt_q(evt_q)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_GLB)) rd_mux[0] = glb_en;
    if (bus_addr == ADDR_W'(A_HEN)) rd_mux[NUM_HOST-1:0] = host_en;
    for (int b = 0; b < BANKS; b++) begin
      if (bus_addr == ADDR_W'(A_STAT + b)) rd_mux = status[b*32 +: 32];
      if (bus_addr == ADDR_W'(A_ENSET + b) || bus_addr == ADDR_W'(A_ENCLR + b))
        rd_mux = enable[b*32 +: 32];
      if (bus_addr == ADDR_W'(A_POL + b)) rd_mux = pol[b*32 +: 32];
      if (bus_addr == ADDR_W'(A_TYP + b)) rd_mux = typ[b*32 +: 32];
    end
    for (int e = 0; e < NUM_EVT; e++)
      if (bus_addr == ADDR_W'(A_CMAP + e / 4)) rd_mux[8*(e%4) +: MAPW] = cmap[e];
    for (int c = 0; c < NUM_CH; c++)
      if (bus_addr == ADDR_W'(A_HMAP + c / 4)) rd_mux[8*(c%4) +: MAPW] = hmap[c];
    for (int h = 0; h < NUM_HOST; h++)
      if (bus_addr == ADDR_W'(A_HIDX + h))
        rd_mux = {none_q[h], 21'b0, IDX_W'(evt_q[h])};
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: tb/icx_top_tb.sv
`timescale 1ns/1ps
module icx_top_tb;
  localparam logic [6:0] GLB = 7'h00, HEN = 7'h01, HSET = 7'h02, HCLR = 7'h03;
  localparam logic [6:0] ISCLR = 7'h04, IESET = 7'h05, IECLR = 7'h06, ISSET = 7'h07;
  localparam logic [6:0] STAT0 = 7'h08, STAT1 = 7'h09, ENS0 = 7'h0A, ENS1 = 7'h0B;
  localparam logic [6:0] ENC0 = 7'h0C, POL0 = 7'h0E, POL1 = 7'h0F, TYP1 = 7'h11;
  localparam logic [6:0] CMAP = 7'h20, HMAP = 7'h30, HIDX = 7'h40;
  localparam logic [31:0] NONE = 32'h8000_0000;

  logic        clk = 0, rst = 1;
  logic [63:0] evt_in = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [9:0]  host_irq;

  int checks = 0, failures = 0;
  logic rd_seen = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  icx_top u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq)
  );

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read data=%h expected none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic chk_irq(input logic [9:0] e, input string t);
    checks++;
    if (host_irq !== e) begin
      failures++;
      $display("FAIL %s host_irq actual=%h expected=%h", t, host_irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(GLB, 0, "R1 glb");
    rd(STAT0, 0, "R1 status");
    rd(POL0, 32'hFFFF_FFFF, "R1 pol0");
    rd(POL1, 32'hFFFF_FFFF, "R1 pol1");
    rd(ENS1, 0, "R1 enable");
    rd(HIDX + 0, NONE, "R1 idx0");
    rd(HIDX + 9, NONE, "R1 idx9");
    chk_irq(10'h000, "R1");
    // R8 channel map packing: ev4->ch1 ev5->ch2 ev6->ch3 ev7->ch0
    wr(CMAP + 1, 32'hF003_0201);
    rd(CMAP + 1, 32'h0003_0201, "R8 cmap1");
    wr(CMAP + 10, 32'h0000_0009);          // ev40 -> ch9
    rd(CMAP + 10, 32'h0000_0009, "R8 cmap10");
    // R9 host map: ch0,1->h0 ch2->h1 ch3->12 (nowhere), ch9->h9
    wr(HMAP + 0, 32'h0C01_0000);
    rd(HMAP + 0, 32'h0C01_0000, "R9 hmap0");
    wr(HMAP + 2, 32'h0707_0900);
    rd(HMAP + 2, 32'h0000_0900, "R9 hmap2");
    wr(HSET, 0); wr(HSET, 1); wr(HSET, 9); wr(HSET, 12);
    rd(HEN, 32'h0000_0203, "R12 host enable");
    wr(GLB, 1);
    wr(ENS0, 32'h10);
    // R2 pulse capture
    @(negedge clk) evt_in[4] = 1;
    idle(3);
    rd(STAT0, 32'h10, "R2 edge");
    rd(HIDX + 0, 32'h4, "R11 idx");
    chk_irq(10'h001, "R12 on");
    wr(STAT0, 32'h10);
    idle(2);
    rd(STAT0, 0, "R2 held no reset");
    @(negedge clk) evt_in[4] = 0;
    @(negedge clk) evt_in[4] = 1;
    @(negedge clk) evt_in[4] = 0;
    idle(3);
    rd(STAT0, 32'h10, "R2 sticky");
    // R10 priority
    wr(IESET, 7); wr(ISSET, 7);
    idle(2);
    rd(HIDX + 0, 32'h7, "R10 channel first");
    wr(IESET, 2); wr(ISSET, 2);
    idle(2);
    rd(HIDX + 0, 32'h2, "R10 event within channel");
    wr(ISCLR, 2);
    idle(2);
    rd(HIDX + 0, 32'h7, "R7 indexed clear");
    wr(STAT0, 32'h80);
    idle(2);
    rd(HIDX + 0, 32'h4, "R11 next");
    wr(STAT0, 32'h10);
    idle(2);
    rd(HIDX + 0, NONE, "R11 none");
    chk_irq(10'h000, "R11 drained");
    // R5 raw status without enable
    @(negedge clk) evt_in[5] = 1;
    @(negedge clk) evt_in[5] = 0;
    idle(3);
    rd(STAT0, 32'h20, "R5 raw");
    rd(HIDX + 1, NONE, "R5 masked");
    chk_irq(10'h000, "R5 masked");
    wr(IESET, 5);
    idle(2);
    rd(HIDX + 1, 32'h5, "R5 enabled");
    chk_irq(10'h002, "R5 enabled");
    // R12 gating
    wr(HCLR, 1);
    idle(2);
    chk_irq(10'h000, "R12 host off");
    rd(HIDX + 1, 32'h5, "R12 idx ungated");
    wr(HSET, 1);
    idle(2);
    chk_irq(10'h002, "R12 host on");
    wr(GLB, 0);
    idle(2);
    chk_irq(10'h000, "R12 global off");
    wr(GLB, 1);
    idle(2);
    chk_irq(10'h002, "R12 global on");
    // R9 out of range host value
    wr(IESET, 6); wr(ISSET, 6);
    idle(2);
    rd(HIDX + 0, NONE, "R9 nowhere");
    chk_irq(10'h002, "R9 nowhere");
    // R6 bitmask writes (enables now 0xF4, status 0x60)
    wr(ENS0, 0);
    rd(ENS0, 32'hF4, "R6 set zero");
    wr(ENC0, 32'h20);
    rd(ENC0, 32'hD4, "R6 clear one bit");
    wr(STAT0, 0);
    rd(STAT0, 32'h60, "R6 status zero");
    idle(1);
    chk_irq(10'h000, "R6 disabled");
    // R7 out-of-range indices
    wr(ISSET, 64); wr(IESET, 70);
    rd(STAT1, 0, "R7 ignore set");
    rd(ENS1, 0, "R7 ignore enable");
    wr(IECLR, 2);
    rd(ENS0, 32'hD0, "R7 indexed enable clear");
    wr(HCLR, 10);
    rd(HEN, 32'h0000_0203, "R12 ignore host 10");
    // R4 polarity: ev40 active-low while line is 0
    wr(ENS1, 32'h100);
    wr(POL1, 32'hFFFF_FEFF);
    idle(3);
    rd(POL1, 32'hFFFF_FEFF, "R4 pol readback");
    rd(STAT1, 32'h100, "R4 active low");
    rd(HIDX + 9, 32'h28, "R11 idx 40");
    chk_irq(10'h200, "R4 irq");
    // R3 level
    wr(TYP1, 32'h100);
    wr(STAT1, 32'h100);
    rd(STAT1, 32'h100, "R3 reasserts");
    @(negedge clk) evt_in[40] = 1;
    idle(1);
    wr(STAT1, 32'h100);
    idle(2);
    rd(STAT1, 0, "R3 cleared inactive");
    chk_irq(10'h000, "R3 cleared");
    // R13 timing
    @(negedge clk) evt_in[40] = 0;
    @(negedge clk) chk_irq(10'h000, "R13 status edge");
    @(negedge clk) chk_irq(10'h200, "R13 output edge");
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule